// File: doc/BRIEF.md
# Protected Save-Area Lock Register

This block is one 8-bit configuration register, together with the address steering it controls, for a protected RAM window that sits at a fixed address. Firmware first asks the register whether the protection feature exists. It does this by writing a query code. If the feature is built in, the register answers with a "backed by RAM" code and reduces its writable bits to one lock bit. Firmware can then set that lock bit. After that the register is frozen until the next reset.

While the window is locked, memory accesses that fall inside it are steered by whether they come from system-management mode. Accesses in that mode go on to RAM. Every other access goes to a black hole instead: reads from the black hole return all ones and writes to it are dropped. A build parameter removes the feature. With the feature removed, the register stays at zero and the window is never protected. The steering outputs are combinational on the current lock state. Register writes take effect at the clock edge.

Top module: `smb_lock`

## Requirements
- R1: After reset the register reads 0x00, all eight bits are writable, and no access is diverted to the black hole.
- R2: In the reset state, a write that produces 0xFF (the query code) makes the register read 0x01 (the "backed by RAM" code) from the next cycle. From then on only bit 1 (the lock bit) is writable.
- R3: In the reset state, a write of any value other than 0xFF is discarded and the register reads 0x00. This includes 0x02, which does not lock.
- R4: After the query, a write with bit 1 clear leaves the register at 0x01, whatever the other bits hold. An example is 0xFD.
- R5: After the query, a write with bit 1 set makes the register read exactly 0x02 from the next cycle and locks the window.
- R6: Once locked, no write changes the register. Examples are 0x00 and 0xFF. It keeps reading 0x02.
- R7: While locked, a valid access that is not in system-management mode and falls in [0x30000, 0x4FFFF] goes to the black hole (holeSel=1, ramSel=0). A read from it returns 0xFFFFFFFF on holeRdata.
- R8: Accesses in system-management mode always go to RAM. Accesses outside the window always go to RAM, so 0x2FFFF and 0x50000 are never diverted.
- R9: Only reset releases the lock. After a reset the query and lock sequence works again.
- R10: With FEATURE_EN=0 the register always reads 0x00, writes including 0xFF and 0x02 have no effect, and nothing is diverted.
- R11: An access in the same cycle as the locking write is still routed to RAM. Diversion starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgWdata | input | 8 | Register write data |
| cfgRdata | output | 8 | Register read value |
| accValid | input | 1 | Memory access present |
| accSmm | input | 1 | Access issued in system-management mode |
| accWrite | input | 1 | Access is a write |
| accAddr | input | 32 | Access byte address |
| ramSel | output | 1 | Forward access to RAM |
| holeSel | output | 1 | Access absorbed by the black hole |
| holeRdata | output | 32 | Black-hole read data |

## Verification
Two functions can meet in one cycle: the register write that sets the lock bit, and a non-SMM access to the window. The bench drives both in the same cycle. It checks that the access is still routed to RAM in that cycle, and that the same access is diverted to the black hole one edge later. A second instance built without the feature receives the same stimulus, which shows that neither function has any effect there.

// File: rtl/smb_lock_pkg.sv
package smb_lock_pkg;
  typedef enum logic [1:0] {
    ST_OPEN    = 2'd0,
    ST_QUERIED = 2'd1,
    ST_LOCKED  = 2'd2
  } lockState_t;

  typedef struct packed {
    logic loadPresent;
    logic loadZero;
    logic loadLock;
    logic locked;
  } lockCtl_t;
endpackage

// File: rtl/smb_lock_ctrl.sv
module smb_lock_ctrl
  import smb_lock_pkg::*;
#(
  parameter int unsigned      REG_W       = 8,
  parameter bit               FEATURE_EN  = 1'b1,
  parameter logic [REG_W-1:0] QUERY_VAL   = 8'hFF,
  parameter logic [REG_W-1:0] LOCK_MASK   = 8'h02
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [REG_W-1:0] mergedVal,
  output lockCtl_t         ctl
);
  lockState_t state, stateNext;
  logic isQuery;
  logic hasLock;

  assign isQuery = (mergedVal == QUERY_VAL);
  assign hasLock = |(mergedVal & LOCK_MASK);

  generate
    if (FEATURE_EN) begin : g_on
      always_comb begin
        stateNext       = state;
        ctl.loadPresent = 1'b0;
        ctl.loadZero    = 1'b0;
        ctl.loadLock    = 1'b0;
        if (cfgWe) begin
          unique case (state)
            ST_OPEN: begin
              if (isQuery) begin
                ctl.loadPresent = 1'b1;
                stateNext       = ST_QUERIED;
              end else begin
                ctl.loadZero = 1'b1;
              end
            end
            ST_QUERIED: begin
              if (hasLock) begin
                ctl.loadLock = 1'b1;
                stateNext    = ST_LOCKED;
              end
            end
            default: ;
          endcase
        end
      end
    end else begin : g_off
      always_comb begin
        stateNext       = ST_OPEN;
        ctl.loadPresent = 1'b0;
        ctl.loadZero    = 1'b0;
        ctl.loadLock    = 1'b0;
      end
    end
  endgenerate

  assign ctl.locked = (state == ST_LOCKED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OPEN;
    else       state <= stateNext;
  end

  // R6: the lock is one-way until reset
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED) |=> (state == ST_LOCKED));

  // R3: a non-query write in the open state leaves it open
  a_r3_open_discard: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && cfgWe && !isQuery) |=> (state == ST_OPEN));

  // R5: locking is only reached from the queried state
  a_r5_lock_after_query: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.locked) |-> ($past(state) == ST_QUERIED));
endmodule

// File: rtl/smb_lock_dp.sv
module smb_lock_dp
  import smb_lock_pkg::*;
#(
  parameter int unsigned       REG_W        = 8,
  parameter int unsigned       ADDR_W       = 32,
  parameter int unsigned       DATA_W       = 32,
  parameter logic [REG_W-1:0]  PRESENT_VAL  = 8'h01,
  parameter logic [REG_W-1:0]  LOCK_MASK    = 8'h02,
  parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] REGION_BYTES = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_W-1:0]  cfgWdata,
  input  lockCtl_t          ctl,
  output logic [REG_W-1:0]  mergedVal,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic              accValid,
  input  logic              accSmm,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              ramSel,
  output logic              holeSel,
  output logic [DATA_W-1:0] holeRdata
);
  localparam logic [ADDR_W-1:0] REGION_LAST = REGION_BASE + REGION_BYTES - 1'b1;
  localparam logic [REG_W-1:0]  FULL_MASK   = {REG_W{1'b1}};

  logic [REG_W-1:0] regVal;
  logic [REG_W-1:0] wMask;
  logic             inRegion;
  logic             divert;

  assign mergedVal = (regVal & ~wMask) | (cfgWdata & wMask);
  assign cfgRdata  = regVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regVal <= '0;
      wMask  <= FULL_MASK;
    end else if (cfgWe) begin
      if (ctl.loadPresent) begin
        regVal <= PRESENT_VAL;
        wMask  <= LOCK_MASK;
      end else if (ctl.loadLock) begin
        regVal <= LOCK_MASK;
        wMask  <= wMask & ~LOCK_MASK;
      end else if (ctl.loadZero) begin
        regVal <= '0;
      end
    end
  end

  assign inRegion  = (accAddr >= REGION_BASE) && (accAddr <= REGION_LAST);
  assign divert    = ctl.locked && inRegion && !accSmm;
  assign ramSel    = accValid && !divert;
  assign holeSel   = accValid && divert;
  assign holeRdata = (holeSel && !accWrite) ? {DATA_W{1'b1}} : '0;

  // R7: an access goes to exactly one target
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !(ramSel && holeSel));

  // R8: system-management accesses always reach RAM
  a_r8_smm_reaches_ram: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSmm) |-> ramSel);

  // R1: the register only ever holds one of its three codes
  a_r1_legal_value: assert property (@(posedge clk) disable iff (!rstN)
    (regVal == '0) || (regVal == PRESENT_VAL) || (regVal == LOCK_MASK));

  // R6: once the mask is empty the register cannot move
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (wMask == '0) |=> $stable(regVal));
endmodule

// File: rtl/smb_lock.sv
module smb_lock
  import smb_lock_pkg::*;
#(
  parameter bit               FEATURE_EN   = 1'b1,
  parameter int unsigned      REG_W        = 8,
  parameter int unsigned      ADDR_W       = 32,
  parameter int unsigned      DATA_W       = 32,
  parameter logic [REG_W-1:0] QUERY_VAL    = 8'hFF,
  parameter logic [REG_W-1:0] PRESENT_VAL  = 8'h01,
  parameter logic [REG_W-1:0] LOCK_MASK    = 8'h02,
  parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] REGION_BYTES = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic              accValid,
  input  logic              accSmm,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              ramSel,
  output logic              holeSel,
  output logic [DATA_W-1:0] holeRdata
);
  lockCtl_t         ctl;
  logic [REG_W-1:0] mergedVal;

  smb_lock_ctrl #(
    .REG_W(REG_W), .FEATURE_EN(FEATURE_EN),
    .QUERY_VAL(QUERY_VAL), .LOCK_MASK(LOCK_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .mergedVal(mergedVal), .ctl(ctl)
  );

  smb_lock_dp #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRESENT_VAL(PRESENT_VAL), .LOCK_MASK(LOCK_MASK),
    .REGION_BASE(REGION_BASE), .REGION_BYTES(REGION_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .ctl(ctl),
    .mergedVal(mergedVal), .cfgRdata(cfgRdata),
    .accValid(accValid), .accSmm(accSmm), .accWrite(accWrite), .accAddr(accAddr),
    .ramSel(ramSel), .holeSel(holeSel), .holeRdata(holeRdata)
  );

  generate
    if (!FEATURE_EN) begin : g_off_chk
      // R10: without the feature nothing is ever diverted
      a_r10_never_hole: assert property (@(posedge clk) disable iff (!rstN)
        !holeSel);
    end
  endgenerate
endmodule

// File: tb/smb_lock_bench.sv
module smb_lock_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic        accValid = 1'b0;
  logic        accSmm = 1'b0;
  logic        accWrite = 1'b0;
  logic [31:0] accAddr = '0;
  logic [7:0]  rdOn, rdOff;
  logic        ramOn, holeOn, ramOff, holeOff;
  logic [31:0] hdOn, hdOff;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  smb_lock u_smb_lock (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(rdOn),
    .accValid(accValid), .accSmm(accSmm), .accWrite(accWrite), .accAddr(accAddr),
    .ramSel(ramOn), .holeSel(holeOn), .holeRdata(hdOn)
  );

  smb_lock #(.FEATURE_EN(1'b0)) u_smb_lock_off (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(rdOff),
    .accValid(accValid), .accSmm(accSmm), .accWrite(accWrite), .accAddr(accAddr),
    .ramSel(ramOff), .holeSel(holeOff), .holeRdata(hdOff)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic smm, input logic wr);
    accValid = 1'b1; accAddr = a; accSmm = smm; accWrite = wr;
    #1;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 reg", rdOn, 8'h00);
    probe(32'h30000, 1'b0, 1'b0);
    chk("R1 ram", ramOn, 1);
    chk("R1 hole", holeOn, 0);
    accValid = 1'b0;
  endtask

  task automatic t_discard();
    doReset();
    cfgWrite(8'h02);
    chk("R3 lock-bit alone discarded", rdOn, 8'h00);
    probe(32'h30000, 1'b0, 1'b0);
    chk("R3 no lock", holeOn, 0);
    accValid = 1'b0;
    cfgWrite(8'h5A);
    chk("R3 other value discarded", rdOn, 8'h00);
  endtask

  task automatic t_query_mask();
    doReset();
    cfgWrite(8'hFF);
    chk("R2 present code", rdOn, 8'h01);
    cfgWrite(8'hFD);
    chk("R4 non-lock bits masked", rdOn, 8'h01);
    cfgWrite(8'h00);
    chk("R4 zero write keeps", rdOn, 8'h01);
    cfgWrite(8'hFF);
    chk("R4 query again sets lock", rdOn, 8'h02);
  endtask

  task automatic t_lock_access();
    doReset();
    cfgWrite(8'hFF);
    cfgWrite(8'h02);
    chk("R5 locked value", rdOn, 8'h02);
    cfgWrite(8'h00);
    chk("R6 write 00 ignored", rdOn, 8'h02);
    cfgWrite(8'hFF);
    chk("R6 write FF ignored", rdOn, 8'h02);
    probe(32'h30000, 1'b0, 1'b0);
    chk("R7 base hole", holeOn, 1);
    chk("R7 base no ram", ramOn, 0);
    chk("R7 hole read data", hdOn, 32'hFFFF_FFFF);
    probe(32'h4FFFF, 1'b0, 1'b1);
    chk("R7 last write dropped", ramOn, 0);
    chk("R7 last hole", holeOn, 1);
    probe(32'h40000, 1'b1, 1'b0);
    chk("R8 smm to ram", ramOn, 1);
    chk("R8 smm no hole", holeOn, 0);
    probe(32'h2FFFF, 1'b0, 1'b0);
    chk("R8 below window", ramOn, 1);
    probe(32'h50000, 1'b0, 1'b0);
    chk("R8 above window", ramOn, 1);
    chk("R10 off never hole", holeOff, 0);
    chk("R10 off reg zero", rdOff, 8'h00);
    accValid = 1'b0;
    #1;
    chk("R7 idle no hole", holeOn, 0);
  endtask

  task automatic t_same_cycle();
    doReset();
    cfgWrite(8'hFF);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = 8'h02;
    probe(32'h38000, 1'b0, 1'b0);
    chk("R11 same-cycle ram", ramOn, 1);
    chk("R11 same-cycle no hole", holeOn, 0);
    @(negedge clk);
    cfgWe = 1'b0;
    #1;
    chk("R11 next-cycle hole", holeOn, 1);
    chk("R11 next-cycle no ram", ramOn, 0);
    chk("R10 off ram", ramOff, 1);
    accValid = 1'b0;
  endtask

  task automatic t_release();
    doReset();
    chk("R9 reset clears", rdOn, 8'h00);
    probe(32'h30000, 1'b0, 1'b0);
    chk("R9 unlocked ram", ramOn, 1);
    accValid = 1'b0;
    cfgWrite(8'hFF);
    chk("R9 query after reset", rdOn, 8'h01);
    chk("R10 off ignores query", rdOff, 8'h00);
    cfgWrite(8'h02);
    chk("R9 relock", rdOn, 8'h02);
    chk("R10 off ignores lock", rdOff, 8'h00);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_discard();
    t_query_mask();
    t_lock_access();
    t_same_cycle();
    t_release();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule